// File: doc/BRIEF.md
# Output Fault Protection Sequencer

This block supervises the enable of a regulated power output. It samples four fault comparators (forward overcurrent, reverse current, over-temperature and supply undervoltage) through a synchroniser. All of its timing is counted in pulses of a 1 ms tick. It drives the output enable and pulses a soft-start request whenever the output comes back on. It also raises overload, back-current and over-temperature status flags and drives an active-low fault line toward the host processor.

Overcurrent is handled in one of two modes. In dynamic mode a sustained overload trips a long off period, after which the output retries. In static mode the output stays on while clamped and only a flag records the event. A sustained reverse current starts a short on / long off retry cycle of its own. Over-temperature turns the output off until the comparator clears. The fourth over-temperature episode locks the output off until the enable input is cycled low and then high again.

Top module: `lnb_fault_seq`

## Requirements
- R1: While rst_ni is low, fault_no, out_en_o, olf_o, bcf_o and otf_o are all 0. Once reset is released with no fault inputs high, fault_no is 1 within 4 clock cycles.
- R2: out_en_o is 1 only when en_i is 1 and no shutdown condition holds. While en_i is 0, out_en_o is 0, and every retry timer and every off period is cleared on the next clock edge.
- R3: In dynamic mode (static_mode_i = 0) with out_en_o high, an overcurrent that stays present for OC_ON_TICKS ticks turns the output off on the following tick. At that point olf_o goes to 1.
- R4: The overload off period lasts OC_OFF_TICKS ticks with olf_o at 1. On its last tick olf_o returns to 0 and the output comes back on. A fault that is still present starts the trip count again.
- R5: In static mode the output is never shut down by overcurrent. olf_o is set by an overcurrent while the output is on, stays set after the overcurrent ends, and clears when ss_done_i pulses.
- R6: A reverse current present for BC_ON_TICKS ticks turns the output off on the following tick, with bcf_o at 1 for BC_OFF_TICKS ticks. After that the output returns, and fault_no is unaffected throughout.
- R7: While the over-temperature comparator is high, otf_o is 1 and out_en_o is 0. When the comparator returns low, both go back to normal.
- R8: On the OT_LIMIT-th over-temperature rising edge seen with en_i high, the part locks off: otf_o stays 1 and out_en_o stays 0 after the comparator falls. Taking en_i low clears the lock and the episode count.
- R9: fault_no goes low one clock after an over-temperature, an overload off period or undervoltage is seen internally. It stays high for a reverse-current off period.
- R10: ss_start_o is a single-cycle pulse. It is asserted one clock after out_en_o rises.
- R11: Each comparator input passes through SYNC_STAGES flops. A change applied before clock edge k is first visible at the outputs after edge k+SYNC_STAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| en_i | input | 1 | Output enable request |
| static_mode_i | input | 1 | 1 selects static current limit, 0 selects dynamic |
| oc_i | input | 1 | Overcurrent comparator, asynchronous |
| bc_i | input | 1 | Reverse-current comparator, asynchronous |
| ot_i | input | 1 | Over-temperature comparator, asynchronous |
| uvlo_i | input | 1 | Supply undervoltage comparator, asynchronous |
| ss_done_i | input | 1 | Soft-start completed pulse |
| out_en_o | output | 1 | Power output enable |
| ss_start_o | output | 1 | Soft-start request pulse |
| olf_o | output | 1 | Overload status flag |
| bcf_o | output | 1 | Back-current status flag |
| otf_o | output | 1 | Over-temperature status flag |
| fault_no | output | 1 | Fault interrupt, active low |

## Verification
With two synchroniser stages, a comparator change becomes visible on out_en_o and the flags two edges after it is driven, and on fault_no one edge later. The bench therefore waits three cycles after each comparator change before it samples. Timer results change on the edge that samples a tick, so the bench checks at the falling edge right after each tick pulse and counts the trip and release ticks exactly. ss_start_o is sampled one edge after the enable rises and again one edge later to confirm that it is a single-cycle pulse.

// File: rtl/lnb_fault_pkg.sv
package lnb_fault_pkg;
  typedef struct packed {
    logic oc;
    logic bc;
    logic ot;
    logic uv;
  } cmp_t;

  // undervoltage reads as present until the synchroniser fills
  localparam cmp_t CMP_RST = '{oc: 1'b0, bc: 1'b0, ot: 1'b0, uv: 1'b1};
endpackage

// File: rtl/lnb_sync.sv
module lnb_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= {STAGES{RST_VAL}};
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lnb_hiccup.sv
module lnb_hiccup #(
  parameter int unsigned ON_TICKS  = 51,
  parameter int unsigned OFF_TICKS = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic fault_i,
  output logic off_o
);
  localparam int unsigned MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic          off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      off_q <= 1'b0;
    end else if (!run_i) begin
      cnt   <= '0;
      off_q <= 1'b0;
    end else if (off_q) begin
      if (tick_i) begin
        if (cnt == CW'(OFF_TICKS - 1)) begin
          cnt   <= '0;
          off_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (!fault_i) begin
      cnt <= '0;
    end else if (tick_i) begin
      // trip on the tick after ON_TICKS full ticks of fault
      if (cnt == CW'(ON_TICKS)) begin
        cnt   <= '0;
        off_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign off_o = off_q;

  assert_stop_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !off_q);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(MAXT));
  assert_trip_needs_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_q) |-> $past(fault_i) && $past(tick_i));
endmodule

// File: rtl/lnb_ot_guard.sv
module lnb_ot_guard #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hot_i,
  output logic latch_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          hot_q;
  logic          latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt     <= '0;
      hot_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      hot_q <= hot_i;
      if (!en_i) begin
        cnt     <= '0;
        latch_q <= 1'b0;
      end else if (hot_i && !hot_q && !latch_q) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LIMIT - 1)) latch_q <= 1'b1;
      end
    end
  end

  assign latch_o = latch_q;

  assert_latch_on_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(cnt) == CW'(LIMIT - 1));
  assert_latch_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && en_i |=> latch_q);
endmodule

// File: rtl/lnb_fault_seq.sv
module lnb_fault_seq
  import lnb_fault_pkg::*;
#(
  parameter int unsigned OC_ON_TICKS  = 51,
  parameter int unsigned OC_OFF_TICKS = 900,
  parameter int unsigned BC_ON_TICKS  = 2,
  parameter int unsigned BC_OFF_TICKS = 50,
  parameter int unsigned OT_LIMIT     = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic static_mode_i,
  input  logic oc_i,
  input  logic bc_i,
  input  logic ot_i,
  input  logic uvlo_i,
  input  logic ss_done_i,
  output logic out_en_o,
  output logic ss_start_o,
  output logic olf_o,
  output logic bcf_o,
  output logic otf_o,
  output logic fault_no
);
  localparam int unsigned CMP_W = $bits(cmp_t);

  cmp_t raw, syn;
  logic run, out_en, oc_off, bc_off, ot_latch, otf;
  logic oc_fault, bc_fault;
  logic olf_st_q, out_en_q, ss_start_q, fault_n_q;

  assign raw = '{oc: oc_i, bc: bc_i, ot: ot_i, uv: uvlo_i};

  lnb_sync #(.W(CMP_W), .STAGES(SYNC_STAGES), .RST_VAL(CMP_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign run      = en_i & ~syn.uv;
  assign out_en   = run & ~oc_off & ~bc_off & ~syn.ot & ~ot_latch;
  assign oc_fault = syn.oc & ~static_mode_i & out_en;
  assign bc_fault = syn.bc & out_en;
  assign otf      = syn.ot | ot_latch;

  lnb_hiccup #(.ON_TICKS(OC_ON_TICKS), .OFF_TICKS(OC_OFF_TICKS)) u_oc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .fault_i(oc_fault),
    .off_o  (oc_off)
  );

  lnb_hiccup #(.ON_TICKS(BC_ON_TICKS), .OFF_TICKS(BC_OFF_TICKS)) u_bc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (run),
    .fault_i(bc_fault),
    .off_o  (bc_off)
  );

  lnb_ot_guard #(.LIMIT(OT_LIMIT)) u_ot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hot_i  (syn.ot),
    .latch_o(ot_latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      olf_st_q   <= 1'b0;
      out_en_q   <= 1'b0;
      ss_start_q <= 1'b0;
      fault_n_q  <= 1'b0;
    end else begin
      if (!static_mode_i || ss_done_i) olf_st_q <= 1'b0;
      else if (syn.oc && out_en)       olf_st_q <= 1'b1;
      out_en_q   <= out_en;
      ss_start_q <= out_en & ~out_en_q;
      fault_n_q  <= ~(otf | oc_off | syn.uv);
    end
  end

  assign out_en_o   = out_en;
  assign ss_start_o = ss_start_q;
  assign olf_o      = static_mode_i ? olf_st_q : oc_off;
  assign bcf_o      = bc_off;
  assign otf_o      = otf;
  assign fault_no   = fault_n_q;

  assert_ss_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_start_o |=> !ss_start_o);
  assert_uvlo_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn.uv |=> !fault_no);
  assert_static_no_trip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode_i |=> !$rose(oc_off));
  assert_trip_from_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_off) |-> $past(out_en_o));
endmodule

// File: tb/lnb_fault_seq_tb.sv
module lnb_fault_seq_tb;
  localparam int unsigned OC_ON  = 3;
  localparam int unsigned OC_OFF = 5;
  localparam int unsigned BC_ON  = 2;
  localparam int unsigned BC_OFF = 4;
  localparam int unsigned OT_LIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, stat = 1'b0;
  logic oc = 1'b0, bc = 1'b0, ot = 1'b0, uvlo = 1'b0, ss_done = 1'b0;
  logic out_en, ss_start, olf, bcf, otf, fault_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lnb_fault_seq #(
    .OC_ON_TICKS(OC_ON), .OC_OFF_TICKS(OC_OFF),
    .BC_ON_TICKS(BC_ON), .BC_OFF_TICKS(BC_OFF),
    .OT_LIMIT(OT_LIM), .SYNC_STAGES(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
    .static_mode_i(stat), .oc_i(oc), .bc_i(bc), .ot_i(ot), .uvlo_i(uvlo),
    .ss_done_i(ss_done), .out_en_o(out_en), .ss_start_o(ss_start),
    .olf_o(olf), .bcf_o(bcf), .otf_o(otf), .fault_no(fault_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    check("R1", "fault_no in reset", fault_n, 1'b0);
    check("R1", "out_en in reset", out_en, 1'b0);
    check("R1", "olf in reset", olf, 1'b0);
    check("R1", "bcf in reset", bcf, 1'b0);
    check("R1", "otf in reset", otf, 1'b0);
    rst_n = 1'b1;
    cyc(4);
    check("R1", "fault_no after reset", fault_n, 1'b1);
    check("R2", "out_en with en low", out_en, 1'b0);

    en = 1'b1;
    cyc(1);
    check("R2", "out_en after enable", out_en, 1'b1);
    check("R10", "ss_start pulse", ss_start, 1'b1);
    cyc(1);
    check("R10", "ss_start single cycle", ss_start, 1'b0);

    // R11: two synchroniser stages
    uvlo = 1'b1;
    cyc(1);
    check("R11", "uvlo not yet visible", out_en, 1'b1);
    cyc(1);
    check("R11", "uvlo visible", out_en, 1'b0);
    cyc(1);
    check("R9", "fault_no on uvlo", fault_n, 1'b0);
    uvlo = 1'b0;
    cyc(3);
    check("R9", "fault_no after uvlo", fault_n, 1'b1);

    // R3/R4 dynamic overload hiccup
    oc = 1'b1;
    cyc(3);
    for (int i = 0; i < int'(OC_ON); i++) begin
      pulse_tick();
      check("R3", "on before trip", out_en, 1'b1);
    end
    pulse_tick();
    check("R3", "out_en at trip", out_en, 1'b0);
    check("R3", "olf at trip", olf, 1'b1);
    cyc(1);
    check("R9", "fault_no in overload off", fault_n, 1'b0);
    for (int i = 0; i < int'(OC_OFF) - 1; i++) begin
      pulse_tick();
      check("R4", "olf during off", olf, 1'b1);
    end
    pulse_tick();
    check("R4", "out_en after off", out_en, 1'b1);
    check("R4", "olf after off", olf, 1'b0);
    for (int i = 0; i < int'(OC_ON); i++) pulse_tick();
    check("R4", "retry still on", out_en, 1'b1);
    pulse_tick();
    check("R4", "retry trips again", olf, 1'b1);
    oc = 1'b0;
    en = 1'b0;
    cyc(1);
    check("R2", "en low clears off", olf, 1'b0);
    en = 1'b1;
    cyc(1);
    check("R2", "output back after en", out_en, 1'b1);

    // R2: en low clears the trip count
    oc = 1'b1;
    cyc(3);
    pulse_tick();
    pulse_tick();
    en = 1'b0;
    cyc(1);
    en = 1'b1;
    cyc(1);
    for (int i = 0; i < int'(OC_ON); i++) pulse_tick();
    check("R2", "count restarted", out_en, 1'b1);
    pulse_tick();
    check("R2", "trip after full count", out_en, 1'b0);
    oc = 1'b0;
    en = 1'b0;
    cyc(3);
    en = 1'b1;
    cyc(2);

    // R5 static mode
    stat = 1'b1;
    oc = 1'b1;
    cyc(3);
    check("R5", "olf set in static", olf, 1'b1);
    for (int i = 0; i < int'(OC_ON + OC_OFF); i++) pulse_tick();
    check("R5", "no shutdown in static", out_en, 1'b1);
    oc = 1'b0;
    cyc(3);
    check("R5", "olf held after clamp", olf, 1'b1);
    ss_done = 1'b1;
    cyc(1);
    ss_done = 1'b0;
    check("R5", "olf cleared by ss_done", olf, 1'b0);
    stat = 1'b0;
    cyc(1);

    // R6 back-current hiccup
    bc = 1'b1;
    cyc(3);
    for (int i = 0; i < int'(BC_ON); i++) pulse_tick();
    check("R6", "on before bc trip", out_en, 1'b1);
    pulse_tick();
    check("R6", "out_en at bc trip", out_en, 1'b0);
    check("R6", "bcf at bc trip", bcf, 1'b1);
    cyc(1);
    check("R6", "fault_no not driven by bc", fault_n, 1'b1);
    bc = 1'b0;
    for (int i = 0; i < int'(BC_OFF) - 1; i++) pulse_tick();
    check("R6", "bcf during off", bcf, 1'b1);
    pulse_tick();
    check("R6", "bcf after off", bcf, 1'b0);
    check("R6", "out_en after bc off", out_en, 1'b1);
    cyc(2);

    // R7/R8 over-temperature and lock
    for (int k = 1; k <= int'(OT_LIM); k++) begin
      ot = 1'b1;
      cyc(3);
      check("R7", "otf while hot", otf, 1'b1);
      check("R7", "out_en while hot", out_en, 1'b0);
      check("R9", "fault_no while hot", fault_n, 1'b0);
      ot = 1'b0;
      cyc(3);
      if (k < int'(OT_LIM)) begin
        check("R7", "otf after cool", otf, 1'b0);
        check("R7", "out_en after cool", out_en, 1'b1);
      end else begin
        check("R8", "otf locked", otf, 1'b1);
        check("R8", "out_en locked", out_en, 1'b0);
        check("R8", "fault_no locked", fault_n, 1'b0);
      end
    end
    en = 1'b0;
    cyc(1);
    check("R8", "lock cleared by en low", otf, 1'b0);
    en = 1'b1;
    cyc(1);
    check("R8", "out_en after unlock", out_en, 1'b1);
    ot = 1'b1;
    cyc(3);
    ot = 1'b0;
    cyc(3);
    check("R8", "count cleared by en low", otf, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule